// File: doc/BRIEF.md
# Triggered Event Buffer with Serial Readout

The block keeps a small first-in first-out store of triggered event records and sends them out one at a time as a serial frame. Each record holds a hit map with one bit per channel, a 4-bit time-over-threshold value and a 5-bit time-stamp. Both fields arrive already Gray coded and are kept bit for bit. A trigger pulse writes the record on the hit inputs. A read pulse takes the oldest record and starts a frame on the serial output, one bit per clock.

A clear pulse throws away every stored record. A sync pulse does the same and also aborts any frame in flight. When nothing is stored, a read produces no output at all: no header and no empty frame.

Top module: `evt_buf`

## Requirements
- R1: After reset the serial valid output is low and the buffer holds no records.
- R2: The buffer holds up to DEPTH records. A trigger that arrives while it is full is dropped and leaves the stored records unchanged. Fullness is judged before any read in the same cycle.
- R3: A read accepted while the buffer is empty gives no output. This includes a trigger and a read in the same cycle on an empty buffer: the trigger is stored and nothing is sent.
- R4: Records leave in trigger order. This still holds after a partial drain followed by a refill.
- R5: A clear pulse empties the buffer. A read or trigger in the same cycle as the clear has no effect. A frame already being sent finishes unchanged.
- R6: A read accepted at a clock edge raises valid in the next cycle. Valid then stays high without a gap for the whole frame. The frame is a 1 start bit, then the chip ID MSB first, then one word per hit channel in ascending channel order, then a single 0 stop bit. Each word is a 1 flag bit, the channel index (clog2(NCH) bits), the time-over-threshold value (4 bits) and the time-stamp (5 bits), each field MSB first.
- R7: The Gray-coded time-over-threshold and time-stamp bits come out exactly as they went in, every bit position on its own.
- R8: A trigger that arrives while a frame is being sent is stored and comes out on a later read.
- R9: A read that arrives while a frame is being sent is ignored and does not take a record.
- R10: A sync pulse empties the buffer and ends any frame in flight. Valid is low in the next cycle.
- R11: A record whose hit map is all zero is sent as the header followed directly by the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_id_i | input | ID_W | Identifier placed in each frame header |
| trig_i | input | 1 | Store the record on the hit inputs |
| hit_i | input | NCH | Channel hit map of the record |
| tot_i | input | 4 | Gray-coded time-over-threshold |
| ts_i | input | 5 | Gray-coded time-stamp |
| rd_i | input | 1 | Start sending the oldest record |
| clr_i | input | 1 | Discard all stored records |
| sync_i | input | 1 | Discard all records and abort the frame |
| ser_o | output | 1 | Serial frame data |
| ser_vld_o | output | 1 | High while a frame bit is on ser_o |

## Verification
The bench builds the block with its defaults: eight channels, four records of storage and a 4-bit chip ID. With eight channels the 3-bit channel index takes every one of its bit values. The four-record depth means a few triggers fill the buffer, so the dropped fifth trigger and the partial-drain-and-refill order can be checked. Walking-one Gray patterns on both fields show each field bit on its own. Clear, sync, reads and triggers are placed inside running frames, so every same-cycle priority is checked against the behavioural queue model.

// File: rtl/evb_pkg.sv
package evb_pkg;
  localparam int TOT_W = 4;
  localparam int TS_W  = 5;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_WORD, S_STOP} ser_st_e;
endpackage

// File: rtl/evb_fifo.sv
module evb_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_n, rd_ptr_q, rd_ptr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          push_ok, pop_ok;

  // fullness is judged on the count before this cycle's pop
  assign push_ok = push_i && !flush_i && (cnt_q != CNT_FULL);
  assign pop_ok  = pop_i && !flush_i && (cnt_q != '0);
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem_q[rd_ptr_q];

  always_comb begin
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    cnt_n    = cnt_q;
    if (flush_i) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      cnt_n    = '0;
    end else begin
      if (push_ok) wr_ptr_n = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + AW'(1);
      if (pop_ok)  rd_ptr_n = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt_n = cnt_q + CW'(1);
        2'b01:   cnt_n = cnt_q - CW'(1);
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      cnt_q    <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_ptr_q] <= din_i;
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !flush_i && cnt_q == CNT_FULL) |=> (cnt_q == CNT_FULL) && $stable(wr_ptr_q));
  a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> empty_o);
  a_r3_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/evb_ser.sv
module evb_ser
  import evb_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int ID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort_i,
  input  logic             load_i,
  input  logic [NCH-1:0]   hit_i,
  input  logic [TOT_W-1:0] tot_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic [ID_W-1:0]  id_i,
  output logic             vld_o,
  output logic             bit_o
);
  localparam int CH_W   = $clog2(NCH);
  localparam int HDR_W  = 1 + ID_W;
  localparam int WORD_W = 1 + CH_W + TOT_W + TS_W;
  localparam int SH_W   = (HDR_W > WORD_W) ? HDR_W : WORD_W;
  localparam int CNT_W  = $clog2(SH_W);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);
  localparam logic [NCH-1:0]   ONE       = NCH'(1);

  ser_st_e          st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [SH_W-1:0]  sh_q, sh_n;
  logic [NCH-1:0]   mask_q, mask_n, rem;
  logic [TOT_W-1:0] tot_q, tot_n;
  logic [TS_W-1:0]  ts_q, ts_n;
  logic [CH_W-1:0]  ch;
  logic [WORD_W-1:0] word;
  logic             last_bit;

  assign vld_o = (st_q != S_IDLE);
  assign bit_o = (st_q == S_HDR || st_q == S_WORD) ? sh_q[SH_W-1] : 1'b0;

  always_comb begin
    // channel of the word being sent is the lowest bit of mask_q
    rem = (st_q == S_WORD) ? (mask_q & (mask_q - ONE)) : mask_q;
    ch  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (rem[i]) ch = CH_W'(i);
    end
    word     = {1'b1, ch, tot_q, ts_q};
    last_bit = (st_q == S_HDR && cnt_q == HDR_LAST) || (st_q == S_WORD && cnt_q == WORD_LAST);

    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    mask_n = mask_q;
    tot_n  = tot_q;
    ts_n   = ts_q;
    case (st_q)
      S_IDLE: begin
        if (load_i) begin
          st_n   = S_HDR;
          cnt_n  = '0;
          sh_n   = SH_W'({1'b1, id_i}) << (SH_W - HDR_W);
          mask_n = hit_i;
          tot_n  = tot_i;
          ts_n   = ts_i;
        end
      end
      S_HDR, S_WORD: begin
        if (last_bit) begin
          cnt_n  = '0;
          mask_n = rem;
          if (rem != '0) begin
            st_n = S_WORD;
            sh_n = SH_W'(word) << (SH_W - WORD_W);
          end else begin
            st_n = S_STOP;
          end
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
          sh_n  = sh_q << 1;
        end
      end
      default: st_n = S_IDLE;
    endcase
    if (abort_i) st_n = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      mask_q <= '0;
      tot_q  <= '0;
      ts_q   <= '0;
    end else begin
      st_q <= st_n;
      if (st_q != S_IDLE || load_i) begin
        cnt_q  <= cnt_n;
        sh_q   <= sh_n;
        mask_q <= mask_n;
        tot_q  <= tot_n;
        ts_q   <= ts_n;
      end
    end
  end

  a_r6_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_o) |-> bit_o);
  a_r9_load_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (st_q == S_IDLE));
  a_r6_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_STOP) |-> !bit_o);
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !vld_o);
endmodule

// File: rtl/evt_buf.sv
module evt_buf
  import evb_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DEPTH = 4,
  parameter int ID_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  chip_id_i,
  input  logic             trig_i,
  input  logic [NCH-1:0]   hit_i,
  input  logic [TOT_W-1:0] tot_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic             rd_i,
  input  logic             clr_i,
  input  logic             sync_i,
  output logic             ser_o,
  output logic             ser_vld_o
);
  localparam int DW = NCH + TOT_W + TS_W;

  logic          flush, start, empty;
  logic [DW-1:0] head;

  assign flush = clr_i || sync_i;
  assign start = rd_i && !flush && !ser_vld_o && !empty;

  evb_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (flush),
    .push_i  (trig_i),
    .pop_i   (start),
    .din_i   ({hit_i, tot_i, ts_i}),
    .dout_o  (head),
    .empty_o (empty)
  );

  evb_ser #(.NCH(NCH), .ID_W(ID_W)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort_i (sync_i),
    .load_i  (start),
    .hit_i   (head[DW-1 -: NCH]),
    .tot_i   (head[TS_W +: TOT_W]),
    .ts_i    (head[TS_W-1:0]),
    .id_i    (chip_id_i),
    .vld_o   (ser_vld_o),
    .bit_o   (ser_o)
  );

  a_r3_empty_read_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && empty && !ser_vld_o) |=> !ser_vld_o);
  a_r6_read_starts: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ser_vld_o && ser_o);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> !ser_vld_o);
endmodule

// File: tb/tb_evt_buf.sv
module tb_evt_buf;
  localparam int NCH = 8, DEPTH = 4, ID_W = 4;
  localparam int CH_W = $clog2(NCH);

  logic clk = 1'b0;
  logic rst_n;
  logic [ID_W-1:0] chip_id_i;
  logic trig_i, rd_i, clr_i, sync_i;
  logic [NCH-1:0] hit_i;
  logic [3:0] tot_i;
  logic [4:0] ts_i;
  logic ser_o, ser_vld_o;

  evt_buf #(.NCH(NCH), .DEPTH(DEPTH), .ID_W(ID_W)) dut (
    .clk(clk), .rst_n(rst_n), .chip_id_i(chip_id_i), .trig_i(trig_i),
    .hit_i(hit_i), .tot_i(tot_i), .ts_i(ts_i), .rd_i(rd_i), .clr_i(clr_i),
    .sync_i(sync_i), .ser_o(ser_o), .ser_vld_o(ser_vld_o)
  );

  always #2 clk = ~clk;

  logic [NCH+8:0] recq[$];
  bit bitq[$];
  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      recq.delete();
      bitq.delete();
    end else begin
      automatic bit busy = bitq.size() > 0;
      automatic bit full = recq.size() >= DEPTH;
      automatic bit emp  = recq.size() == 0;
      if (busy) void'(bitq.pop_front());
      if (sync_i) bitq.delete();
      if (clr_i || sync_i) recq.delete();
      else begin
        if (rd_i && !busy && !emp) begin
          automatic logic [NCH+8:0] r = recq.pop_front();
          bitq.push_back(1'b1);
          for (int k = ID_W - 1; k >= 0; k--) bitq.push_back(chip_id_i[k]);
          for (int c = 0; c < NCH; c++) begin
            if (r[9 + c]) begin
              bitq.push_back(1'b1);
              for (int k = CH_W - 1; k >= 0; k--) bitq.push_back(c[k]);
              for (int k = 8; k >= 0; k--) bitq.push_back(r[k]);
            end
          end
          bitq.push_back(1'b0);
        end
        if (trig_i && !full) recq.push_back({hit_i, tot_i, ts_i});
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit ev = bitq.size() > 0;
      automatic bit eb = ev ? bitq[0] : 1'b0;
      n_chk++;
      if (ser_vld_o !== ev || (ev && ser_o !== eb)) begin
        n_fail++;
        $display("FAIL %s: vld/bit actual %b/%b expected %b/%b at %0t",
                 tag, ser_vld_o, ser_o, ev, eb, $time);
      end
    end
  end

  function automatic logic [4:0] gray(input int b);
    return 5'(b ^ (b >> 1));
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic trig(input logic [NCH-1:0] h, input logic [3:0] t, input logic [4:0] s);
    trig_i = 1; hit_i = h; tot_i = t; ts_i = s;
    tick();
    trig_i = 0;
  endtask

  task automatic rd();
    rd_i = 1; tick(); rd_i = 0;
  endtask

  task automatic drain();
    tick();
    while (bitq.size() > 0) tick();
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run actual unfinished, expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; trig_i = 0; rd_i = 0; clr_i = 0; sync_i = 0;
    hit_i = '0; tot_i = '0; ts_i = '0; chip_id_i = 4'hA;
    repeat (3) tick();
    n_chk++;
    if (ser_vld_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: reset vld actual %b expected 0", ser_vld_o);
    end
    rst_n = 1;
    tick();

    // R1 / R3: read of an empty buffer, and trigger with read on empty
    tag = "R3";
    rd(); repeat (4) tick();
    trig_i = 1; rd_i = 1; hit_i = 8'h12; tot_i = 4'h3; ts_i = 5'h06;
    tick(); trig_i = 0; rd_i = 0;
    repeat (3) tick();
    rd(); drain();

    // R2: fill, fifth trigger dropped, five reads
    tag = "R2";
    for (int i = 0; i < DEPTH; i++) trig(8'h55 << i, gray(i + 1)[3:0], gray(3 * i + 2));
    trig(8'hFF, 4'hF, 5'h1F);
    for (int i = 0; i < 5; i++) begin rd(); drain(); end

    // R4: partial drain then refill keeps order
    tag = "R4";
    for (int i = 0; i < 4; i++) trig(8'h81 >> i, gray(i + 5)[3:0], gray(i + 9));
    rd(); drain(); rd(); drain();
    trig(8'h3C, 4'h6, 5'h11);
    trig(8'hC3, 4'h9, 5'h0A);
    for (int i = 0; i < 5; i++) begin rd(); drain(); end

    // R5: clear discards, beats same-cycle trigger/read, frame finishes
    tag = "R5";
    for (int i = 0; i < 4; i++) trig(8'h0F, gray(i)[3:0], gray(i));
    clr_i = 1; tick(); clr_i = 0;
    rd(); drain();
    trig(8'h01, 4'h1, 5'h01);
    clr_i = 1; trig_i = 1; rd_i = 1; hit_i = 8'h02; tick();
    clr_i = 0; trig_i = 0; rd_i = 0;
    rd(); drain();
    trig(8'hA5, 4'hC, 5'h13);
    trig(8'h5A, 4'h2, 5'h0E);
    rd(); repeat (3) tick();
    clr_i = 1; tick(); clr_i = 0;
    drain(); rd(); drain();

    // R8: trigger during a frame is kept
    tag = "R8";
    trig(8'h44, 4'h5, 5'h07);
    rd(); repeat (4) tick();
    trig(8'h22, 4'hA, 5'h15);
    drain(); rd(); drain();

    // R9: read during a frame is ignored
    tag = "R9";
    trig(8'h11, 4'h3, 5'h03);
    trig(8'h88, 4'h8, 5'h18);
    rd(); repeat (2) tick(); rd();
    drain(); rd(); drain(); rd(); drain();

    // R7: walking-one Gray bits, all channels hit
    tag = "R7";
    for (int b = 0; b < 5; b++) begin
      trig(8'hFF, (b < 4) ? 4'(1 << b) : 4'h0, 5'(1 << b));
      rd(); drain();
    end

    // R11: empty hit map
    tag = "R11";
    trig(8'h00, 4'h7, 5'h1B);
    rd(); drain();

    // R6: other chip ID, end channels
    tag = "R6";
    chip_id_i = 4'h5;
    trig(8'h81, 4'hE, 5'h1D);
    rd(); drain();

    // R10: sync aborts frame and empties buffer
    tag = "R10";
    for (int i = 0; i < 3; i++) trig(8'hF0, 4'h4, 5'h05);
    rd(); repeat (3) tick();
    sync_i = 1; tick(); sync_i = 0;
    drain(); rd(); drain();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule